// File: doc/BRIEF.md
# Two-Wire Write-Only Control Register Slave

This block is a receive-only slave on a two-wire serial bus (SCL clock, SDA data). It oversamples both lines in its own system clock domain and detects start and stop conditions and the bit clock on the sampled lines. After a start it compares the first byte with a fixed 7-bit device address and a write direction bit. The second byte is a subaddress that selects one of sixteen register indices and sets a step mode. All bytes after that are data that land in a bank of eight 8-bit control registers.

There are two step modes. In the first, every data byte goes to the register that was selected. In the second, the index advances by one after each byte. Indices 8 to 15 decode normally but have no storage, so a master that runs through them in stepping mode must send filler bytes. Each accepted byte is acknowledged by pulling SDA low through an open-drain enable. Each register write raises a one-cycle strobe next to the register output, so downstream logic can pick up the new setting.

Top module: `ctl_bus_slave`

## Requirements
- R1: After reset all register outputs are 0x00, all update strobes are low and sda_oe is low.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are taken when SCL rises, most significant bit first, eight bits to a byte.
- R3: When the first byte after a start is 0x88 (address 7'h44 followed by write bit 0), the block drives SDA low during the ninth clock. It does the same for the subaddress and for every data byte after it. sda_oe changes only while the sampled SCL is low.
- R4: A data byte written to index i (0..7) appears on regs_o[8*i+7:8*i] and raises upd_o[i] for exactly one system clock. A register output never changes without its strobe.
- R5: Any other first byte (including 0x89, the read direction) gets no acknowledge, and no byte is acknowledged or written until the next start.
- R6: In the subaddress byte, bits 3..0 are the index, bit 4 is the step flag and bits 7..5 are ignored. With the step flag 0, every data byte before the stop goes to the same index.
- R7: With the step flag 1, the first data byte goes to the selected index and each later byte goes to the previous index plus one.
- R8: Data bytes aimed at indices 8..15 are acknowledged but change no register and raise no strobe.
- R9: In stepping mode, once the index passes 15 it stays out of range: later bytes are acknowledged and discarded, and the index never wraps to 0.
- R10: A start in the middle of a transfer, including inside a byte, drops the partial byte and begins address matching again.
- R11: After a stop, bits clocked without a new start are not acknowledged and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | 64 | Eight register values, index i in bits 8*i+7..8*i |
| upd_o | output | 8 | One-cycle write strobe for each register |

## Verification
The hardest situations to reach are a start that arrives after only part of a data byte has been shifted in, and a stepping write that starts near the top of the index space and runs past 15. Both need exact control of individual SCL and SDA edges. The bench drives the bus bit by bit through tasks. It cuts a byte off after three bits and then issues a start, and it starts stepping writes at indices 6 and 14. It sends enough bytes that a wrap to index 0 would show up in a register the reference model still expects to hold its earlier value.

// File: rtl/ctl_bus_slave.sv
module ctl_bus_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int DW   = 8,
  parameter int NREG = 8,
  parameter int IDXW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  output logic [NREG*DW-1:0]   regs_o,
  output logic [NREG-1:0]      upd_o
);
  localparam int PW = IDXW + 1;
  localparam int AW = $clog2(NREG);
  localparam int CW = $clog2(DW + 1);
  localparam logic [PW-1:0] NREG_P = PW'(NREG);
  localparam logic [CW-1:0] DW_P = CW'(DW);

  typedef enum logic [2:0] {IDLE, ADDR, SUB, DATA, SKIP} st_t;

  logic [1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;
  st_t st;
  logic [DW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic in_ack, inc;
  logic [PW-1:0] idx;
  logic [DW-1:0] regs [NREG];

  wire scl_s   = scl_sr[1];
  wire sda_s   = sda_sr[1];
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise    = scl_s & ~scl_d;
  wire fall    = ~scl_s & scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= 2'b11;
      sda_sr <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[0], scl_i};
      sda_sr <= {sda_sr[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      shreg  <= '0;
      cnt    <= '0;
      in_ack <= 1'b0;
      inc    <= 1'b0;
      idx    <= '0;
      sda_oe <= 1'b0;
      upd_o  <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      upd_o <= '0;
      if (start_c) begin
        st     <= ADDR;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (st != IDLE) begin
        if (rise && !in_ack && cnt < DW_P) begin
          shreg <= {shreg[DW-2:0], sda_s};
          cnt   <= cnt + 1'b1;
        end else if (fall && in_ack) begin
          in_ack <= 1'b0;
          sda_oe <= 1'b0;
          cnt    <= '0;
        end else if (fall && cnt == DW_P) begin
          in_ack <= 1'b1;
          case (st)
            ADDR: begin
              if (shreg == {DEV_ADDR, 1'b0}) begin
                sda_oe <= 1'b1;
                st     <= SUB;
              end else begin
                st <= SKIP;
              end
            end
            SUB: begin
              idx    <= PW'(shreg[IDXW-1:0]);
              inc    <= shreg[IDXW];
              sda_oe <= 1'b1;
              st     <= DATA;
            end
            DATA: begin
              sda_oe <= 1'b1;
              if (idx < NREG_P) begin
                regs[idx[AW-1:0]]  <= shreg;
                upd_o[idx[AW-1:0]] <= 1'b1;
              end
              if (inc && !idx[PW-1]) idx <= idx + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/ctl_bus_slave_chk.sv
module ctl_bus_slave_chk #(
  parameter int DW   = 8,
  parameter int NREG = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               sda_oe,
  input logic [2:0]         st,
  input logic [NREG*DW-1:0] regs_o,
  input logic [NREG-1:0]    upd_o
);
  p_stb_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_o));

  p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o != '0) |=> (upd_o == '0));

  p_reg_needs_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> (upd_o != '0));

  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_write_in_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o != '0) |-> ($past(st) == 3'd3));
endmodule

bind ctl_bus_slave ctl_bus_slave_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .st(st), .regs_o(regs_o), .upd_o(upd_o)
);

// File: tb/sim_ctl_bus_slave.sv
`timescale 1ns/1ps
module sim_ctl_bus_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] regs_o;
  logic [7:0] upd_o;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  ctl_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs_o), .upd_o(upd_o)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] m_reg [8];
  int m_stb [8];
  int a_stb [8];
  int hold = 0;
  int phase = 4;
  int m_idx = 0;
  bit m_inc = 0;
  bit exp_ack = 0;

  initial for (int i = 0; i < 8; i++) begin m_reg[i] = 8'h00; m_stb[i] = 0; a_stb[i] = 0; end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 8; i++) if (upd_o[i]) a_stb[i]++;
      if (hold > 0) hold--;
      else begin
        for (int i = 0; i < 8; i++) begin
          checks++;
          if (regs_o[8*i +: 8] !== m_reg[i]) begin
            errors++;
            $display("FAIL R4 reg%0d actual %02h expected %02h at %0t", i, regs_o[8*i +: 8], m_reg[i], $time);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (phase)
      0: begin exp_ack = (b == 8'h88); phase = exp_ack ? 1 : 3; end
      1: begin exp_ack = 1; m_idx = b[3:0]; m_inc = b[4]; phase = 2; end
      2: begin
        exp_ack = 1;
        if (m_idx < 8) begin m_reg[m_idx] = b; m_stb[m_idx]++; end
        if (m_inc) m_idx++;
      end
      default: exp_ack = 0;
    endcase
    hold = 8;
  endtask

  task automatic send_bit(input logic v);
    sda_m = v; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int k = 7; k > 7 - n; k--) begin
      send_bit(b[k]);
      tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    logic got;
    for (int k = 7; k >= 0; k--) begin
      send_bit(b[k]);
      if (k == 0) model_byte(b);
      tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    got = ~sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
    checks++;
    if (got !== exp_ack) begin
      errors++;
      $display("FAIL %s ack for byte %02h actual %0b expected %0b", req, b, got, exp_ack);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
    phase = 0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
    phase = 4;
  endtask

  task automatic check_all(input string req);
    tick(10);
    for (int i = 0; i < 8; i++) begin
      checks++;
      if (regs_o[8*i +: 8] !== m_reg[i] || a_stb[i] != m_stb[i]) begin
        errors++;
        $display("FAIL %s reg%0d actual %02h/%0d strobes expected %02h/%0d strobes",
                 req, i, regs_o[8*i +: 8], a_stb[i], m_reg[i], m_stb[i]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    checks++;
    if (regs_o !== 64'h0 || upd_o !== 8'h0 || sda_oe !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual %016h %02h %0b expected 0 0 0", regs_o, upd_o, sda_oe);
    end

    // R2 R6: fixed index, three bytes to index 2
    bus_start();
    send_byte(8'h88, "R3"); send_byte(8'h02, "R3");
    send_byte(8'h11, "R3"); send_byte(8'h22, "R6"); send_byte(8'h33, "R6");
    bus_stop();
    check_all("R2 R6");

    // R7: stepping from index 0, upper subaddress bits set
    bus_start();
    send_byte(8'h88, "R3"); send_byte(8'hF0, "R7");
    for (int k = 0; k < 5; k++) send_byte(8'hA0 + 8'(k), "R7");
    bus_stop();
    check_all("R7");

    // R8: index 9 has no storage
    bus_start();
    send_byte(8'h88, "R3"); send_byte(8'h09, "R8");
    for (int k = 0; k < 4; k++) send_byte(8'h5C + 8'(k), "R8");
    bus_stop();
    check_all("R8");

    // R9: stepping past 7 and past 15
    bus_start();
    send_byte(8'h88, "R3"); send_byte(8'h16, "R9");
    send_byte(8'h66, "R9"); send_byte(8'h77, "R9");
    send_byte(8'h88, "R9"); send_byte(8'h99, "R9");
    bus_stop();
    bus_start();
    send_byte(8'h88, "R3"); send_byte(8'h1E, "R9");
    send_byte(8'hC1, "R9"); send_byte(8'hC2, "R9"); send_byte(8'hC3, "R9");
    bus_stop();
    check_all("R9");

    // R5: wrong address, then read direction
    bus_start();
    send_byte(8'h8A, "R5"); send_byte(8'h01, "R5"); send_byte(8'hEE, "R5");
    bus_start();
    send_byte(8'h89, "R5"); send_byte(8'h01, "R5"); send_byte(8'hEE, "R5");
    bus_stop();
    check_all("R5");

    // R10: start inside a byte, and start between bytes
    bus_start();
    send_byte(8'h88, "R3"); send_byte(8'h03, "R10");
    send_bits(8'hE5, 3);
    bus_start();
    send_byte(8'h88, "R10"); send_byte(8'h05, "R10"); send_byte(8'h5A, "R10");
    bus_start();
    send_byte(8'h8A, "R10"); send_byte(8'h77, "R10");
    bus_stop();
    check_all("R10");

    // R11: clocking after stop without a start
    scl_m = 1'b0; tick(Q);
    send_byte(8'h88, "R11"); send_byte(8'h01, "R11"); send_byte(8'hEE, "R11");
    check_all("R11");
    bus_start();
    bus_stop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule